// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator

This block collects interrupt events from a USB OTG controller core and presents them to a host CPU as one level interrupt. Events fall into two groups. The endpoint group holds one bit for each transmit and receive endpoint. The core group holds the controller's nine general event lines. Each group keeps a sticky source register, a mask and a masked view of the two. Software can set or clear bits in the source and mask registers through separate alias addresses. This also lets it inject an event, such as a VBUS-drive event, that the hardware never raised.

The CPU interrupt works with an arm and re-arm handshake. The line rises when the block is armed and some masked bit is pending. It stays high while anything is pending. Once the pending bits have been serviced, the line stays low, even if new events arrive, until software writes the end-of-interrupt register.

The block also has a fixed revision word, a status word that reflects the VBUS-drive input, and a control register whose bit 0 is a self-clearing soft reset. Access is through a 32-bit single-cycle register port. Reads are combinational on `bus_rdata` during the cycle in which `bus_valid` is high.

Top module: `usb_irq_gather`

## Requirements
- R1: Register word addresses are fixed as follows. Revision is at 0x00, control at 0x04 and status at 0x08. The endpoint group uses 0x20 (source), 0x24 (source set), 0x28 (source clear), 0x2C (mask), 0x30 (mask set), 0x34 (mask clear) and 0x38 (masked view). The core group uses the same seven-register pattern from 0x40 to 0x58. End-of-interrupt is at 0x60. A write to a group's source or mask base address loads it directly, limited to that group's valid bits.
- R2: In the endpoint group, bits 15:0 belong to transmit endpoints 0 to 15 and bits 31:17 belong to receive endpoints 1 to 15. Bit 16 always reads 0, and writes or events cannot set it.
- R3: In the core group, the nine event lines map to bits 24:16, and the VBUS-drive event is bit 24. All other bits of the core registers read 0.
- R4: Each masked-view address reads as its group's source ANDed with its mask. The interrupt output is high only when at least one masked bit is set.
- R5: At the set and clear aliases, a 1 bit sets or clears the matching bit and a 0 bit leaves it unchanged. A read of an alias address returns the underlying register.
- R6: An event pulse on `ep_event` or `core_event` sets the matching source bit, and the bit stays set until software clears it. If a clear write to a bit arrives in the same cycle as an event pulse on that bit, the bit ends up set.
- R7: After reset the block is armed. `irq_out` rises when the block is armed and a masked bit is pending, and it stays high while a masked bit remains pending. Once it has fallen, it stays low until a write to the end-of-interrupt address. The value written there is ignored.
- R8: Writing 1 to control bit 0 clears every source and mask bit and re-arms the interrupt. The control register reads as 0.
- R9: The revision address returns the nonzero parameter `REV_ID`. Status bit 0 reflects `vbus_drive`, and the other status bits read 0.
- R10: Reads of unmapped addresses return 0. Writes to the revision, status and masked-view addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is strobed |
| ep_event | input | 32 | Endpoint event pulses in source-bit layout |
| core_event | input | 9 | Core event pulses, line 8 is VBUS-drive |
| vbus_drive | input | 1 | VBUS-drive level shown in status |
| irq_out | output | 1 | Level interrupt to the CPU |

## Verification
Two functions can fall in the same cycle: a software clear through the source-clear alias and a hardware event pulse on the same bit. The bench drives both in one cycle, clearing two endpoint bits while an event arrives on only one of them. It then reads the source register and expects the pulsed bit to be set and the other bit to be cleared. The same overlap is examined for the interrupt handshake. An event that becomes pending after service must leave the line low, and the line must come back only after the end-of-interrupt write.

// File: rtl/usb_irq_gather.sv
module usb_irq_gather #(
  parameter logic [31:0] REV_ID     = 32'h0001_0200,
  parameter int          CORE_LINES = 9,
  parameter int          CORE_LSB   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] ep_event,
  input  logic [CORE_LINES-1:0] core_event,
  input  logic        vbus_drive,
  output logic        irq_out
);
  localparam logic [31:0] EP_VALID   = 32'hFFFE_FFFF;
  localparam logic [31:0] CORE_VALID =
    {{(32-CORE_LINES){1'b0}}, {CORE_LINES{1'b1}}} << CORE_LSB;

  logic [31:0] ep_src, ep_mask, core_src, core_mask;
  logic        armed, live;

  wire [5:0]  word    = bus_addr[7:2];
  wire        wr      = bus_valid & bus_write;
  wire        sreset  = wr && word == 6'd1 && bus_wdata[0];
  wire        eoi     = wr && word == 6'd24;
  wire [31:0] ep_msk  = ep_src & ep_mask;
  wire [31:0] co_msk  = core_src & core_mask;
  wire        pending = |ep_msk | |co_msk;
  wire [31:0] ep_ev   = ep_event & EP_VALID;
  wire [31:0] co_ev   = ({{(32-CORE_LINES){1'b0}}, core_event} << CORE_LSB) & CORE_VALID;

  assign irq_out = pending & (armed | live);

  function automatic logic [31:0] upd(input logic [31:0] cur, input logic [5:0] base,
                                      input logic [31:0] valid);
    logic [31:0] v;
    v = cur;
    if (wr && word == base)           v = bus_wdata;
    if (wr && word == base + 6'd1)    v = cur | bus_wdata;
    if (wr && word == base + 6'd2)    v = cur & ~bus_wdata;
    return v & valid;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_src <= '0; ep_mask <= '0; core_src <= '0; core_mask <= '0;
      armed <= 1'b1; live <= 1'b0;
    end else if (sreset) begin
      ep_src <= '0; ep_mask <= '0; core_src <= '0; core_mask <= '0;
      armed <= 1'b1; live <= 1'b0;
    end else begin
      ep_src    <= upd(ep_src, 6'd8, EP_VALID) | ep_ev;
      ep_mask   <= upd(ep_mask, 6'd11, EP_VALID);
      core_src  <= upd(core_src, 6'd16, CORE_VALID) | co_ev;
      core_mask <= upd(core_mask, 6'd19, CORE_VALID);
      if (eoi) begin
        armed <= 1'b1;
        live  <= 1'b0;
      end else if (irq_out) begin
        armed <= 1'b0;
        live  <= 1'b1;
      end else begin
        live  <= 1'b0;
      end
    end
  end

  always_comb begin
    case (word)
      6'd0:                  bus_rdata = REV_ID;
      6'd2:                  bus_rdata = {31'b0, vbus_drive};
      6'd8, 6'd9, 6'd10:     bus_rdata = ep_src;
      6'd11, 6'd12, 6'd13:   bus_rdata = ep_mask;
      6'd14:                 bus_rdata = ep_msk;
      6'd16, 6'd17, 6'd18:   bus_rdata = core_src;
      6'd19, 6'd20, 6'd21:   bus_rdata = core_mask;
      6'd22:                 bus_rdata = co_msk;
      default:               bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/usb_irq_gather_chk.sv
module usb_irq_gather_chk #(
  parameter logic [31:0] REV_ID = 32'h0001_0200
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] ep_event,
  input logic        irq_out,
  input logic        armed,
  input logic [31:0] ep_src,
  input logic [31:0] ep_mask,
  input logic [31:0] core_src,
  input logic [31:0] core_mask
);
  wire        rd_req = bus_valid && !bus_write;
  wire        sreset = bus_valid && bus_write && bus_addr[7:2] == 6'd1 && bus_wdata[0];
  wire [31:0] ep_ev  = ep_event & 32'hFFFE_FFFF;

  p_bit16_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_addr[7:2] == 6'd8) |-> !bus_rdata[16]);

  p_irq_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (((ep_src & ep_mask) | (core_src & core_mask)) != 32'd0));

  p_event_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ep_ev != 32'd0) && !sreset) |=> ((ep_src & $past(ep_ev)) == $past(ep_ev)));

  p_rise_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> armed);

  p_arm_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(irq_out));

  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (ep_src == 32'd0 && ep_mask == 32'd0 && core_src == 32'd0 &&
                core_mask == 32'd0 && armed));

  p_revision_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_addr[7:2] == 6'd0) |-> bus_rdata == REV_ID);
endmodule

bind usb_irq_gather usb_irq_gather_chk #(.REV_ID(REV_ID)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ep_event(ep_event), .irq_out(irq_out), .armed(armed),
  .ep_src(ep_src), .ep_mask(ep_mask), .core_src(core_src), .core_mask(core_mask)
);

// File: tb/test_usb_irq_gather.sv
module test_usb_irq_gather;
  localparam logic [31:0] REV = 32'h0001_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ep_event = '0;
  logic [8:0]  core_event = '0;
  logic        vbus_drive = 1'b0;
  logic        irq_out;
  logic        probe = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  usb_irq_gather #(.REV_ID(REV)) i_usb_irq_gather (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ep_event(ep_event), .core_event(core_event), .vbus_drive(vbus_drive),
    .irq_out(irq_out)
  );

  always @(negedge clk) begin
    #5;
    if ((bus_valid && !bus_write) || probe) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = probe ? {31'b0, irq_out} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; ep_event = '0; core_event = '0; probe = 1'b0;
  endtask

  task automatic wr_ev(input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] ev, input logic [8:0] cev);
    @(negedge clk);
    probe = 1'b0;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    ep_event = ev; core_event = cev;
    idle();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_ev(a, d, '0, '0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    idle();
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
    probe = 1'b1;
    idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(8'h00, REV, "R9 revision");
    rd(8'h20, 32'h0, "R1 ep source reset");
    rd(8'h2C, 32'h0, "R1 ep mask reset");
    rd(8'h04, 32'h0, "R8 control reads zero");
    chk_irq(1'b0, "R7 idle after reset");
    // mask direct load, bit 16 dropped
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, 32'hFFFE_FFFF, "R2 ep mask bit16");
    wr(8'h34, 32'hFFFF_0000);
    rd(8'h2C, 32'h0000_FFFF, "R5 mask clear alias");
    rd(8'h30, 32'h0000_FFFF, "R5 alias reads register");
    // inject through set alias
    wr(8'h24, 32'h0003_0005);
    rd(8'h20, 32'h0002_0005, "R2 source set drops bit16");
    rd(8'h38, 32'h0000_0005, "R4 ep masked view");
    chk_irq(1'b1, "R7 irq held while pending");
    // service, then new event must wait for end-of-interrupt
    wr(8'h28, 32'h0000_0005);
    chk_irq(1'b0, "R7 irq low after service");
    wr(8'h24, 32'h0000_0001);
    chk_irq(1'b0, "R7 stays low without eoi");
    wr(8'h60, 32'hDEAD_BEEF);
    chk_irq(1'b1, "R7 eoi re-arms");
    rd(8'h20, 32'h0002_0001, "R5 set alias keeps others");
    // core group
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h4C, 32'h01FF_0000, "R3 core mask valid bits");
    wr(8'h44, 32'h0100_0000);
    rd(8'h58, 32'h0100_0000, "R3 vbus-drive bit24 masked");
    // hardware events, and clear colliding with event
    wr_ev(8'h00, 32'h0, 32'h8000_0010, 9'h000);
    rd(8'h20, 32'h8002_0011, "R6 event sets sticky bits");
    wr_ev(8'h28, 32'h0000_0081, 32'h0000_0080, 9'h001);
    rd(8'h20, 32'h8002_0090, "R6 event wins over clear");
    rd(8'h40, 32'h0101_0000, "R6 core event line0 to bit16");
    // read-only and unmapped
    wr(8'h38, 32'h0);
    rd(8'h38, 32'h0000_0090, "R10 masked view write ignored");
    wr(8'h00, 32'h0);
    rd(8'h00, REV, "R10 revision write ignored");
    rd(8'h7C, 32'h0, "R10 unmapped read");
    rd(8'h10, 32'h0, "R10 unmapped low read");
    // status
    vbus_drive = 1'b1;
    rd(8'h08, 32'h1, "R9 status vbus");
    vbus_drive = 1'b0;
    rd(8'h08, 32'h0, "R9 status vbus low");
    // soft reset
    wr(8'h04, 32'h1);
    rd(8'h20, 32'h0, "R8 ep source cleared");
    rd(8'h2C, 32'h0, "R8 ep mask cleared");
    rd(8'h4C, 32'h0, "R8 core mask cleared");
    rd(8'h40, 32'h0, "R8 core source cleared");
    rd(8'h04, 32'h0, "R8 control self clears");
    chk_irq(1'b0, "R8 irq low after soft reset");
    wr(8'h2C, 32'h1);
    wr(8'h24, 32'h1);
    chk_irq(1'b1, "R8 soft reset re-arms");
    rd(8'h1C, 32'h0, "R1 unused word reads zero");
    repeat (3) idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule